// File: doc/BRIEF.md
# Register Rename Stage with Zero-Idiom Elimination

This block is the rename stage of an out-of-order core. Each cycle it takes a group of up to four decoded micro-ops. Each micro-op has an operation class, two architectural source registers and one architectural destination. The stage translates every register name into a physical register tag, using a mapping table and a bitmap of unused physical registers. The translated group appears on the outputs in the same cycle. Each output lane also carries a flag that says whether the micro-op has to be sent to the execution units.

Exclusive-or and subtract of a register with itself always yield zero. The stage handles these itself. It points the destination at physical tag 0, a register that is permanently zero and never handed out. It does not allocate a tag and marks the micro-op as needing no dispatch. Such a micro-op does not look up the mapping of its source, so it depends on no earlier producer. A compare-equal of a register with itself yields all ones. It also drops its dependency, but it still needs a new tag and still needs execution. An add of a register with itself keeps its real dependency.

Retirement hands old tags back through a set of release ports. When there are too few unused tags for the group, the stage holds the group off and changes no state.

Top module: `zero_idiom_renamer`

## Requirements
- R1: A group has up to LANES=4 lanes, each with its own valid bit. Class codes are 2 bits: 0 = general (add and other ops), 1 = exclusive-or, 2 = subtract, 3 = compare-equal producing all ones. Lane l's results appear on output lane l combinationally in the cycle the group is presented, and the stage's state advances at the next clock edge.
- R2: After reset, architectural register i maps to physical tag i+1. Tag 0 is the zero register. Tags NARCH+1 to NPHYS-1 are unused, and the stage is ready.
- R3: A valid lane with class 1 or 2 whose two source fields are equal is a zero idiom. Its output destination tag is 0, it takes no tag, and it is accepted even when no tags are unused.
- R4: Every other valid lane takes the lowest-numbered unused tag. Lanes are served in order, lane 0 first.
- R5: The dispatch flag is 0 for a zero idiom and 1 for every other valid accepted lane.
- R6: A lane of class 1, 2 or 3 whose two source fields are equal reports both physical sources as tag 0, which means it has no dependency.
- R7: Every other lane reports the current mapping of each source, including a class 0 lane whose two sources are equal.
- R8: Within a group, a lane reads mappings that already include the destinations written by earlier lanes of the same group, including tag 0 from an idiom.
- R9: Each accepted lane reports the destination's previous mapping. Earlier lanes of the same group are included when working this out.
- R10: If the number of unused tags is less than the number of non-idiom valid lanes, ready is low, no output lane is valid, and neither the mapping nor the unused set changes.
- R11: A tag released at a clock edge becomes available for allocation from the next cycle on. A release of tag 0 is ignored.
- R12: Tag 0 is never marked unused and never allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | LANES | Per-lane valid |
| grp_cls | input | 2*LANES | Per-lane operation class |
| grp_srca | input | AW*LANES | Per-lane first architectural source |
| grp_srcb | input | AW*LANES | Per-lane second architectural source |
| grp_dst | input | AW*LANES | Per-lane architectural destination |
| grp_ready | output | 1 | Group accepted this cycle |
| ren_valid | output | LANES | Per-lane renamed result valid |
| ren_dispatch | output | LANES | Per-lane needs execution |
| ren_psrca | output | PW*LANES | Physical tag of first source |
| ren_psrcb | output | PW*LANES | Physical tag of second source |
| ren_pdst | output | PW*LANES | New physical destination tag |
| ren_pold | output | PW*LANES | Previous physical tag of destination |
| rel_valid | input | RETIRE | Per-port release valid |
| rel_tag | input | PW*RETIRE | Released physical tag |

## Verification
The assertions assume that retirement never releases a tag that is already unused, and one of them checks that assumption at the release ports. They also assume that a released tag is no longer named by the mapping. The bench meets both conditions. It releases only previous-mapping tags that the stage reported for accepted lanes, each one once, and never tag 0 except in the one step that checks a tag-0 release is ignored. The random phase mixes idioms, same-source adds and compare-equals, and heavy allocation, so that stalls happen and are released again.

// File: rtl/zero_idiom_renamer.sv
module zero_idiom_renamer #(
  parameter int LANES  = 4,
  parameter int NARCH  = 16,
  parameter int NPHYS  = 48,
  parameter int RETIRE = 4,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      grp_valid,
  input  logic [2*LANES-1:0]    grp_cls,
  input  logic [AW*LANES-1:0]   grp_srca,
  input  logic [AW*LANES-1:0]   grp_srcb,
  input  logic [AW*LANES-1:0]   grp_dst,
  output logic                  grp_ready,
  output logic [LANES-1:0]      ren_valid,
  output logic [LANES-1:0]      ren_dispatch,
  output logic [PW*LANES-1:0]   ren_psrca,
  output logic [PW*LANES-1:0]   ren_psrcb,
  output logic [PW*LANES-1:0]   ren_pdst,
  output logic [PW*LANES-1:0]   ren_pold,
  input  logic [RETIRE-1:0]     rel_valid,
  input  logic [PW*RETIRE-1:0]  rel_tag
);

  localparam logic [1:0] CLS_GEN = 2'd0;
  localparam logic [1:0] CLS_XOR = 2'd1;
  localparam logic [1:0] CLS_SUB = 2'd2;

  logic [PW-1:0]    map_q [NARCH];
  logic [PW-1:0]    map_d [NARCH];
  logic [NPHYS-1:0] free_q, free_alloc, rel_mask;
  logic [LANES-1:0] same, idiom;
  int unsigned      need;
  logic [PW-1:0]    pick;
  logic             found;

  always_comb begin
    need = 0;
    for (int l = 0; l < LANES; l++) begin
      same[l]  = grp_srca[l*AW +: AW] == grp_srcb[l*AW +: AW];
      idiom[l] = grp_valid[l] && same[l] &&
                 (grp_cls[l*2 +: 2] == CLS_XOR || grp_cls[l*2 +: 2] == CLS_SUB);
      if (grp_valid[l] && !idiom[l]) need++;
    end
  end

  assign grp_ready = $countones(free_q) >= need;

  always_comb begin
    map_d        = map_q;
    free_alloc   = free_q;
    ren_valid    = '0;
    ren_dispatch = '0;
    ren_psrca    = '0;
    ren_psrcb    = '0;
    ren_pdst     = '0;
    ren_pold     = '0;
    pick         = '0;
    found        = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (grp_valid[l] && grp_ready) begin
        ren_valid[l] = 1'b1;
        ren_pold[l*PW +: PW] = map_d[grp_dst[l*AW +: AW]];
        if (!(same[l] && grp_cls[l*2 +: 2] != CLS_GEN)) begin
          ren_psrca[l*PW +: PW] = map_d[grp_srca[l*AW +: AW]];
          ren_psrcb[l*PW +: PW] = map_d[grp_srcb[l*AW +: AW]];
        end
        pick  = '0;
        found = 1'b0;
        if (!idiom[l]) begin
          ren_dispatch[l] = 1'b1;
          for (int p = 1; p < NPHYS; p++) begin
            if (!found && free_alloc[p]) begin
              pick          = PW'(p);
              found         = 1'b1;
              free_alloc[p] = 1'b0;
            end
          end
        end
        ren_pdst[l*PW +: PW] = pick;
        map_d[grp_dst[l*AW +: AW]] = pick;
      end
    end
  end

  always_comb begin
    rel_mask = '0;
    for (int k = 0; k < RETIRE; k++)
      if (rel_valid[k] && rel_tag[k*PW +: PW] != '0 && int'(rel_tag[k*PW +: PW]) < NPHYS)
        rel_mask[rel_tag[k*PW +: PW]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= PW'(i + 1);
      for (int p = 0; p < NPHYS; p++) free_q[p] <= (p > NARCH);
    end else begin
      map_q  <= map_d;
      free_q <= free_alloc | rel_mask;
    end
  end

  // R12
  zero_never_free_chk: assert property (@(posedge clk) disable iff (!rst_n) !free_q[0]);

  // R10
  stall_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_ready |-> ren_valid == '0);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_ready && rel_valid == '0) |=> $stable(free_q));

  genvar gl, gk;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane_chk
      // R5
      dispatch_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid[gl] && ren_dispatch[gl]) |-> ren_pdst[gl*PW +: PW] != '0);
      // R4
      alloc_was_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid[gl] && ren_dispatch[gl]) |-> free_q[ren_pdst[gl*PW +: PW]]);
      // R3
      idiom_zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid[gl] && !ren_dispatch[gl]) |-> ren_pdst[gl*PW +: PW] == '0);
    end
    for (gk = 0; gk < RETIRE; gk++) begin : g_rel_chk
      // R11
      rel_not_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid[gk] && rel_tag[gk*PW +: PW] != '0 && int'(rel_tag[gk*PW +: PW]) < NPHYS)
          |-> !free_q[rel_tag[gk*PW +: PW]]);
    end
  endgenerate

endmodule

// File: tb/tb_zero_idiom_renamer.sv
module tb_zero_idiom_renamer;
  localparam int LANES = 4, NARCH = 16, NPHYS = 48, RETIRE = 4;
  localparam int AW = 4, PW = 6;

  logic clk = 0, rst_n = 0;
  logic [LANES-1:0] grp_valid = '0;
  logic [2*LANES-1:0] grp_cls = '0;
  logic [AW*LANES-1:0] grp_srca = '0, grp_srcb = '0, grp_dst = '0;
  logic grp_ready;
  logic [LANES-1:0] ren_valid, ren_dispatch;
  logic [PW*LANES-1:0] ren_psrca, ren_psrcb, ren_pdst, ren_pold;
  logic [RETIRE-1:0] rel_valid = '0;
  logic [PW*RETIRE-1:0] rel_tag = '0;

  zero_idiom_renamer dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic rdy;
    logic [LANES-1:0] v, d;
    logic [PW*LANES-1:0] sa, sb, pd, po;
    string req;
  } exp_t;

  exp_t scb[$];
  logic [PW-1:0] pool[$];
  int checks = 0, errs = 0;
  bit done = 0;

  logic [PW-1:0] mdl_map [NARCH];
  logic [NPHYS-1:0] mdl_free;

  logic [LANES-1:0] g_v;
  logic [1:0] g_cls [LANES];
  logic [AW-1:0] g_a [LANES], g_b [LANES], g_d [LANES];
  logic [RETIRE-1:0] g_rv;
  logic [PW-1:0] g_rt [RETIRE];

  task automatic clr();
    g_v = '0; g_rv = '0;
    for (int l = 0; l < LANES; l++) begin g_cls[l] = 0; g_a[l] = 0; g_b[l] = 0; g_d[l] = 0; end
    for (int k = 0; k < RETIRE; k++) g_rt[k] = 0;
  endtask

  task automatic lane(input int l, input logic [1:0] c, input int a, input int b, input int d);
    g_v[l] = 1; g_cls[l] = c; g_a[l] = AW'(a); g_b[l] = AW'(b); g_d[l] = AW'(d);
  endtask

  function automatic bit is_zi(int l);
    return g_v[l] && g_a[l] == g_b[l] && (g_cls[l] == 2'd1 || g_cls[l] == 2'd2);
  endfunction

  task automatic step(input string req);
    exp_t e;
    logic [PW-1:0] m [NARCH];
    logic [NPHYS-1:0] f;
    int need;
    logic [PW-1:0] t;
    @(negedge clk);
    grp_valid = g_v; rel_valid = g_rv;
    for (int l = 0; l < LANES; l++) begin
      grp_cls[l*2 +: 2] = g_cls[l];
      grp_srca[l*AW +: AW] = g_a[l]; grp_srcb[l*AW +: AW] = g_b[l]; grp_dst[l*AW +: AW] = g_d[l];
    end
    for (int k = 0; k < RETIRE; k++) rel_tag[k*PW +: PW] = g_rt[k];
    m = mdl_map; f = mdl_free; need = 0;
    for (int l = 0; l < LANES; l++) if (g_v[l] && !is_zi(l)) need++;
    e.rdy = $countones(f) >= need;
    e.v = e.rdy ? g_v : '0; e.d = '0;
    e.sa = '0; e.sb = '0; e.pd = '0; e.po = '0; e.req = req;
    for (int l = 0; l < LANES; l++) begin
      if (g_v[l] && e.rdy) begin
        e.po[l*PW +: PW] = m[g_d[l]];
        if (!(g_a[l] == g_b[l] && g_cls[l] != 0)) begin
          e.sa[l*PW +: PW] = m[g_a[l]];
          e.sb[l*PW +: PW] = m[g_b[l]];
        end
        t = 0;
        if (!is_zi(l)) begin
          e.d[l] = 1;
          for (int p = NPHYS - 1; p >= 1; p--) if (f[p]) t = PW'(p);
          f[t] = 0;
        end
        e.pd[l*PW +: PW] = t;
        m[g_d[l]] = t;
        if (e.po[l*PW +: PW] != 0) pool.push_back(e.po[l*PW +: PW]);
      end
    end
    scb.push_back(e);
    if (e.rdy) begin mdl_map = m; mdl_free = f; end
    for (int k = 0; k < RETIRE; k++) if (g_rv[k] && g_rt[k] != 0) mdl_free[g_rt[k]] = 1;
    clr();
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected group per driven cycle
  initial begin
    exp_t e;
    forever begin
      @(negedge clk); #1;
      if (scb.size() != 0) begin
        e = scb.pop_front();
        chk(grp_ready == e.rdy, e.req, "ready", int'(grp_ready), int'(e.rdy));
        for (int l = 0; l < LANES; l++) begin
          chk(ren_valid[l] == e.v[l], e.req, $sformatf("lane%0d valid", l), int'(ren_valid[l]), int'(e.v[l]));
          if (e.v[l]) begin
            chk(ren_dispatch[l] == e.d[l], e.req, $sformatf("lane%0d dispatch", l), int'(ren_dispatch[l]), int'(e.d[l]));
            chk(ren_psrca[l*PW +: PW] == e.sa[l*PW +: PW], e.req, $sformatf("lane%0d psrca", l), int'(ren_psrca[l*PW +: PW]), int'(e.sa[l*PW +: PW]));
            chk(ren_psrcb[l*PW +: PW] == e.sb[l*PW +: PW], e.req, $sformatf("lane%0d psrcb", l), int'(ren_psrcb[l*PW +: PW]), int'(e.sb[l*PW +: PW]));
            chk(ren_pdst[l*PW +: PW] == e.pd[l*PW +: PW], e.req, $sformatf("lane%0d pdst", l), int'(ren_pdst[l*PW +: PW]), int'(e.pd[l*PW +: PW]));
            chk(ren_pold[l*PW +: PW] == e.po[l*PW +: PW], e.req, $sformatf("lane%0d pold", l), int'(ren_pold[l*PW +: PW]), int'(e.po[l*PW +: PW]));
          end
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NARCH; i++) mdl_map[i] = PW'(i + 1);
    for (int p = 0; p < NPHYS; p++) mdl_free[p] = (p > NARCH);
    clr();
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(ren_valid == '0, "R2", "valid in reset", int'(ren_valid), 0);
    chk(grp_ready == 1'b1, "R2", "ready in reset", int'(grp_ready), 1);
    rst_n = 1;
    // R2 R7 R4: initial mapping and lowest-first allocation
    lane(0, 0, 0, 1, 4); lane(1, 0, 2, 3, 5); lane(2, 0, 14, 15, 6); lane(3, 0, 7, 8, 9);
    step("R2");
    // R3 R5 R6: exclusive-or and subtract idioms
    lane(0, 1, 5, 5, 5); lane(1, 2, 6, 6, 10); lane(2, 2, 6, 7, 11);
    step("R3");
    // R7: add of a register with itself keeps the dependency
    lane(0, 0, 8, 8, 8); lane(1, 0, 8, 8, 8);
    step("R7");
    // R6: compare-equal all ones breaks the dependency but still dispatches and allocates
    lane(0, 3, 9, 9, 12); lane(1, 3, 9, 1, 13);
    step("R6");
    // R8 R9: forwarding through an idiom and repeated destinations
    lane(0, 1, 2, 2, 2); lane(1, 0, 2, 3, 3); lane(2, 0, 3, 2, 2); lane(3, 2, 3, 3, 3);
    step("R8");
    lane(0, 0, 3, 2, 4); lane(1, 0, 4, 4, 4); lane(2, 0, 4, 0, 4); lane(3, 0, 4, 4, 1);
    step("R9");
    // R10: drain to empty, then stall
    while ($countones(mdl_free) >= 4) begin
      for (int l = 0; l < 4; l++) lane(l, 0, l, l + 4, l + 8);
      step("R4");
    end
    for (int l = 0; l < $countones(mdl_free); l++) lane(l, 0, 1, 2, l + 1);
    step("R4");
    lane(0, 0, 1, 2, 3); lane(1, 1, 4, 4, 4);
    step("R10");
    // R3: idiom-only group accepted with no unused tag
    lane(0, 1, 6, 6, 6); lane(1, 2, 7, 7, 7);
    step("R3");
    // R11: tag 0 release ignored
    g_rv[0] = 1; g_rt[0] = 0;
    lane(0, 0, 1, 2, 3);
    step("R11");
    lane(0, 0, 1, 2, 3);
    step("R11");
    // R11: release usable only next cycle
    g_rv[0] = 1; g_rt[0] = pool.pop_front();
    lane(0, 0, 1, 2, 3);
    step("R11");
    lane(0, 0, 1, 2, 3);
    step("R11");
    // random mix
    for (int n = 0; n < 2000; n++) begin
      for (int l = 0; l < LANES; l++) begin
        if ($urandom_range(0, 3) != 0) begin
          int a = $urandom_range(0, NARCH - 1);
          lane(l, 2'($urandom_range(0, 3)), a, ($urandom_range(0, 1) != 0) ? a : int'($urandom_range(0, NARCH - 1)),
               $urandom_range(0, NARCH - 1));
        end
      end
      for (int k = 0; k < RETIRE; k++)
        if (pool.size() != 0 && $urandom_range(0, 1) != 0) begin g_rv[k] = 1; g_rt[k] = pool.pop_front(); end
      step("R12");
    end
    step("R1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule